// File: doc/BRIEF.md
# Self-Timed Program Cycle Controller

This block sits behind a serial command decoder in a small non-volatile store. Each time the decoder finishes shifting in a command, it presents a one-clock strobe with an operation code, a word address and a data word. The controller keeps a write-enable latch and accepts programming commands only while that latch is set and the supply is good. It holds an accepted command until chip select falls, and then runs a timed program cycle on an external register-file array through a simple write port.

A word write erases the addressed word to all ones in the first cycle of the program window and programs the data in the last cycle. A fill of the whole array works the same way, with an erase of every word first. A plain erase writes ones in the final cycle only. The host checks progress by raising chip select again after it has been low for a minimum time. Data out then drives low while the cycle runs and high once the array is ready. It releases on the next falling edge of chip select.

Top module: `prog_cycle_ctrl`

## Requirements
- R1: After reset the block is write-disabled, `busy`, `arrWe` and `doOe` are low.
- R2: While write-disabled, a program command (erase=1, erase-all=2, write=3, write-all=4 on `cmdOp`) starts no cycle and causes no array write.
- R3: An accepted program command starts its cycle only at the first clock edge that samples `csIn` low after sampling it high. `busy` is then high for exactly `WORD_CYCLES` clocks for a word operation. A word erase makes one array write of all ones, with `arrAll` low, in the last busy clock, and `busy` clears at the edge that performs it.
- R4: A word write makes exactly two array writes: all ones in the first busy clock and the command data in the last busy clock.
- R5: An erase-all keeps `busy` high for `ALL_CYCLES` clocks and makes one write of all ones with `arrAll` high in the last busy clock.
- R6: A write-all keeps `busy` high for `ALL_CYCLES` clocks. It writes all ones with `arrAll` high in the first busy clock and the data with `arrAll` high in the last.
- R7: The disable command (6) blocks every later program command until an enable command (5) is accepted.
- R8: Once started, a cycle runs to completion while `csIn` toggles. A command that arrives while `busy` is high is ignored and later starts no cycle.
- R9: If `csIn` rises while busy after being sampled low on at least `CS_LOW_MIN` clock edges, `doOe` goes high. `doVal` is then 0 while busy and 1 once the cycle has ended. A rise after a shorter low time leaves `doOe` low.
- R10: `doOe` goes low after the clock edge that samples the falling edge of `csIn`. It stays low for a whole cycle during which `csIn` is kept low.
- R11: While `pwrGood` is low, no command is accepted and no array write is made. A running cycle ends at the first edge that samples `pwrGood` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| pwrGood | input | 1 | Supply above programming threshold |
| csIn | input | 1 | Chip select from the serial interface |
| cmdValid | input | 1 | One-clock strobe: a decoded command is complete |
| cmdOp | input | 3 | Operation code |
| cmdAddr | input | ADDR_W | Word address of the command |
| cmdData | input | DATA_W | Data word of the command |
| arrWe | output | 1 | Array write enable |
| arrAll | output | 1 | Write applies to every word |
| arrAddr | output | ADDR_W | Array word address |
| arrData | output | DATA_W | Array write data |
| busy | output | 1 | Program cycle in progress |
| doOe | output | 1 | Data-out status drive enable |
| doVal | output | 1 | Data-out status level (1 ready, 0 busy) |

## Verification
On every clock, the assertions check the following: a cycle starts only on a sampled chip-select fall while enabled, no array write happens without good power or outside a cycle, the erase and data strobes never coincide, status drive appears only after a long enough low time and drops after a fall, and a power loss ends a cycle at once. The bench scenarios are the only evidence of the end results: the exact busy length, where the erase and data writes fall within the window, the array contents after random word operations, and that a disable, a power loss or a command sent while busy leaves the array untouched.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

  typedef enum logic [2:0] {
    OP_NONE      = 3'd0,
    OP_ERASE     = 3'd1,
    OP_ERASE_ALL = 3'd2,
    OP_WRITE     = 3'd3,
    OP_WRITE_ALL = 3'd4,
    OP_ENABLE    = 3'd5,
    OP_DISABLE   = 3'd6
  } cmd_op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;     // latch command address and data
    logic fillOnes;    // write all-ones pattern
    logic fillData;    // write latched data
    logic wholeArray;  // write targets every word
  } arr_strobe_t;

endpackage

// File: rtl/pcc_ctrl.sv
module pcc_ctrl
  import pcc_pkg::*;
#(
  parameter int WORD_CYCLES = 20,  // must be at least 2
  parameter int ALL_CYCLES  = 60,  // must be at least WORD_CYCLES
  parameter int CS_LOW_MIN  = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pwrGood,
  input  logic        csIn,
  input  logic        cmdValid,
  input  logic [2:0]  cmdOp,
  output arr_strobe_t strobe,
  output logic        busy,
  output logic        doOe,
  output logic        doVal
);

  localparam int CNT_W = $clog2(ALL_CYCLES + 1);
  localparam int LOW_W = $clog2(CS_LOW_MIN + 1);

  cmd_op_e         op;
  logic            csQ, wrEn, pendValid, pendAll, pendWrite;
  logic            runAll, runWrite, firstQ, statusEn;
  logic [CNT_W-1:0] cnt;
  logic [LOW_W-1:0] lowCnt;
  logic            accept, isProg, csFall, csRise, startCyc, active, lastCyc;

  assign op       = cmd_op_e'(cmdOp);
  assign accept   = cmdValid & csIn & ~busy & pwrGood;
  assign isProg   = op inside {OP_ERASE, OP_ERASE_ALL, OP_WRITE, OP_WRITE_ALL};
  assign csFall   = csQ & ~csIn;
  assign csRise   = ~csQ & csIn;
  assign startCyc = csFall & pendValid & pwrGood & ~busy;
  assign active   = busy & pwrGood;
  assign lastCyc  = cnt == '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csQ       <= 1'b0;
      wrEn      <= 1'b0;
      pendValid <= 1'b0;
      pendAll   <= 1'b0;
      pendWrite <= 1'b0;
      runAll    <= 1'b0;
      runWrite  <= 1'b0;
      firstQ    <= 1'b0;
      busy      <= 1'b0;
      cnt       <= '0;
      lowCnt    <= '0;
      statusEn  <= 1'b0;
    end else begin
      csQ <= csIn;

      // chip-select low-time measurement, saturating
      if (csIn)                           lowCnt <= '0;
      else if (lowCnt < LOW_W'(CS_LOW_MIN)) lowCnt <= lowCnt + 1'b1;

      if (csFall)
        statusEn <= 1'b0;
      else if (csRise && busy && lowCnt >= LOW_W'(CS_LOW_MIN))
        statusEn <= 1'b1;

      if (accept) begin
        if (op == OP_ENABLE) begin
          wrEn      <= 1'b1;
          pendValid <= 1'b0;
        end else if (op == OP_DISABLE) begin
          wrEn      <= 1'b0;
          pendValid <= 1'b0;
        end else if (isProg) begin
          pendValid <= wrEn;
          pendAll   <= (op == OP_ERASE_ALL) || (op == OP_WRITE_ALL);
          pendWrite <= (op == OP_WRITE) || (op == OP_WRITE_ALL);
        end
      end
      if (!pwrGood) pendValid <= 1'b0;

      if (startCyc) begin
        busy      <= 1'b1;
        pendValid <= 1'b0;
        runAll    <= pendAll;
        runWrite  <= pendWrite;
        firstQ    <= 1'b1;
        cnt       <= pendAll ? CNT_W'(ALL_CYCLES - 1) : CNT_W'(WORD_CYCLES - 1);
      end else if (busy) begin
        firstQ <= 1'b0;
        if (!pwrGood || lastCyc) busy <= 1'b0;
        else                     cnt  <= cnt - 1'b1;
      end
    end
  end

  always_comb begin
    strobe.capture    = accept & isProg & wrEn;
    strobe.fillOnes   = active & ((firstQ & runWrite) | (lastCyc & ~runWrite));
    strobe.fillData   = active & lastCyc & runWrite;
    strobe.wholeArray = active & runAll;
  end

  assign doOe  = statusEn;
  assign doVal = ~busy;

  p_start_on_fall_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(csQ) && !$past(csIn)));
  p_start_enabled_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wrEn));
  p_no_pend_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !pendValid);
  p_status_low_time_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doOe) |-> ($past(lowCnt) >= LOW_W'(CS_LOW_MIN)));
  p_status_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    (csQ && !csIn) |=> !doOe);
  p_pg_abort_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !pwrGood) |=> !busy);

endmodule

// File: rtl/pcc_datapath.sv
module pcc_datapath
  import pcc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  arr_strobe_t       strobe,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  output logic              arrWe,
  output logic              arrAll,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [DATA_W-1:0] arrData
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else if (strobe.capture) begin
      addrQ <= cmdAddr;
      dataQ <= cmdData;
    end
  end

  assign arrWe   = strobe.fillOnes | strobe.fillData;
  assign arrAll  = strobe.wholeArray;
  assign arrAddr = addrQ;
  assign arrData = strobe.fillOnes ? '1 : dataQ;

  p_single_fill_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.fillOnes && strobe.fillData));
  p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    arrWe |-> ($stable(addrQ) && $stable(dataQ)));

endmodule

// File: rtl/prog_cycle_ctrl.sv
module prog_cycle_ctrl
  import pcc_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int WORD_CYCLES = 20,
  parameter int ALL_CYCLES  = 60,
  parameter int CS_LOW_MIN  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrGood,
  input  logic              csIn,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  output logic              arrWe,
  output logic              arrAll,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [DATA_W-1:0] arrData,
  output logic              busy,
  output logic              doOe,
  output logic              doVal
);

  arr_strobe_t strobe;

  pcc_ctrl #(
    .WORD_CYCLES(WORD_CYCLES),
    .ALL_CYCLES (ALL_CYCLES),
    .CS_LOW_MIN (CS_LOW_MIN)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .pwrGood (pwrGood),
    .csIn    (csIn),
    .cmdValid(cmdValid),
    .cmdOp   (cmdOp),
    .strobe  (strobe),
    .busy    (busy),
    .doOe    (doOe),
    .doVal   (doVal)
  );

  pcc_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) uData (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .cmdAddr(cmdAddr),
    .cmdData(cmdData),
    .arrWe  (arrWe),
    .arrAll (arrAll),
    .arrAddr(arrAddr),
    .arrData(arrData)
  );

  p_we_needs_power_r11: assert property (@(posedge clk) disable iff (!rstN)
    arrWe |-> pwrGood);
  p_we_in_cycle_r3: assert property (@(posedge clk) disable iff (!rstN)
    arrWe |-> busy);

endmodule

// File: tb/sim_prog_cycle_ctrl.sv
module sim_prog_cycle_ctrl;
  import pcc_pkg::*;

  localparam int CLK_P  = 10;
  localparam int AW     = 8;
  localparam int DW     = 16;
  localparam int WORDC  = 20;
  localparam int ALLC   = 60;
  localparam int LOWMIN = 4;
  localparam int DEPTH  = 1 << AW;
  localparam logic [DW-1:0] ONES = '1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwrGood = 1'b1;
  logic csIn = 1'b0;
  logic cmdValid = 1'b0;
  logic [2:0] cmdOp = 3'd0;
  logic [AW-1:0] cmdAddr = '0;
  logic [DW-1:0] cmdData = '0;
  logic arrWe, arrAll, busy, doOe, doVal;
  logic [AW-1:0] arrAddr;
  logic [DW-1:0] arrData;

  prog_cycle_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WORD_CYCLES(WORDC),
                    .ALL_CYCLES(ALLC), .CS_LOW_MIN(LOWMIN)) u0 (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .csIn(csIn),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .arrWe(arrWe), .arrAll(arrAll), .arrAddr(arrAddr), .arrData(arrData),
    .busy(busy), .doOe(doOe), .doVal(doVal));

  always #(CLK_P/2) clk = ~clk;

  logic [DW-1:0] arr    [DEPTH];
  logic [DW-1:0] expArr [DEPTH];
  int checkCount = 0, failCount = 0;
  int busyCnt, weCount, firstPos, lastPos, oeSeen;
  logic [DW-1:0] firstData, lastData;
  logic firstAll, lastAll;
  bit done = 0;

  // array model driven by the write port, sampled mid-cycle
  always @(negedge clk) begin
    #1;
    if (rstN) begin
      if (busy) busyCnt++;
      if (doOe) oeSeen++;
      if (arrWe) begin
        weCount++;
        if (weCount == 1) begin
          firstPos = busyCnt; firstData = arrData; firstAll = arrAll;
        end
        lastPos = busyCnt; lastData = arrData; lastAll = arrAll;
        if (arrAll) for (int i = 0; i < DEPTH; i++) arr[i] = arrData;
        else arr[arrAddr] = arrData;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #2;
  endtask

  task automatic clearMon();
    busyCnt = 0; weCount = 0; firstPos = 0; lastPos = 0; oeSeen = 0;
    firstData = '0; lastData = '0; firstAll = 0; lastAll = 0;
  endtask

  task automatic sendCmd(input cmd_op_e op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    tick(); csIn = 1'b1; cmdValid = 1'b1; cmdOp = op; cmdAddr = a; cmdData = d;
    tick(); cmdValid = 1'b0;
  endtask

  task automatic dropCs();
    tick(); csIn = 1'b0;
  endtask

  task automatic waitIdle(input string tag);
    bit idle = 0;
    for (int i = 0; i < 500; i++) begin
      tick();
      if (!busy) begin idle = 1; break; end
    end
    check(idle, {tag, " cycle ends"}, 64'(busy), 64'd0);
  endtask

  function automatic bit isAllOp(input cmd_op_e op);
    return op == OP_ERASE_ALL || op == OP_WRITE_ALL;
  endfunction
  function automatic bit isWriteOp(input cmd_op_e op);
    return op == OP_WRITE || op == OP_WRITE_ALL;
  endfunction

  task automatic applyExp(input cmd_op_e op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [DW-1:0] v = isWriteOp(op) ? d : ONES;
    if (isAllOp(op)) for (int i = 0; i < DEPTH; i++) expArr[i] = v;
    else expArr[a] = v;
  endtask

  task automatic cmpAll(input string tag);
    int bad = -1;
    for (int i = DEPTH - 1; i >= 0; i--) if (arr[i] !== expArr[i]) bad = i;
    if (bad < 0) check(1, tag, 0, 0);
    else check(0, tag, 64'(arr[bad]), 64'(expArr[bad]));
  endtask

  // checks after an enabled program cycle has completed
  task automatic checkCycle(input cmd_op_e op, input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    int len = isAllOp(op) ? ALLC : WORDC;
    check(busyCnt == len, {tag, " busy length"}, 64'(busyCnt), 64'(len));
    if (isWriteOp(op)) begin
      check(weCount == 2, {tag, " two writes"}, 64'(weCount), 64'd2);
      check(firstPos == 1 && firstData == ONES && firstAll == isAllOp(op),
            {tag, " erase first"}, {32'(firstPos), 16'(firstData)}, {32'd1, 16'(ONES)});
      check(lastPos == len && lastData == d && lastAll == isAllOp(op),
            {tag, " data last"}, {32'(lastPos), 16'(lastData)}, {32'(len), 16'(d)});
    end else begin
      check(weCount == 1, {tag, " one write"}, 64'(weCount), 64'd1);
      check(lastPos == len && lastData == ONES && lastAll == isAllOp(op),
            {tag, " ones last"}, {32'(lastPos), 16'(lastData)}, {32'(len), 16'(ONES)});
    end
    applyExp(op, a, d);
    if (isAllOp(op)) cmpAll({tag, " array"});
    else check(arr[a] === expArr[a], {tag, " word"}, 64'(arr[a]), 64'(expArr[a]));
  endtask

  task automatic runOp(input cmd_op_e op, input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    clearMon();
    sendCmd(op, a, d);
    dropCs();
    waitIdle(tag);
    checkCycle(op, a, d, tag);
  endtask

  task automatic noEffect(input cmd_op_e op, input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    clearMon();
    sendCmd(op, a, d);
    dropCs();
    repeat (WORDC + 10) tick();
    check(busyCnt == 0 && weCount == 0, {tag, " no cycle"}, 64'(busyCnt + weCount), 64'd0);
    check(arr[a] === expArr[a], {tag, " word unchanged"}, 64'(arr[a]), 64'(expArr[a]));
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checkCount++; failCount++;
      $display("FAIL watchdog: run did not finish actual=1 expected=0");
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end

  initial begin
    cmd_op_e rop;
    logic [AW-1:0] ra;
    logic [DW-1:0] rd;
    void'($urandom(32'h1F3A));
    for (int i = 0; i < DEPTH; i++) begin arr[i] = '0; expArr[i] = '0; end
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1
    check(!busy && !arrWe && !doOe, "R1 reset outputs", {busy, arrWe, doOe}, 0);

    // R2: disabled after reset
    noEffect(OP_ERASE, 8'd5, '0, "R2 erase while disabled");
    noEffect(OP_WRITE_ALL, 8'd0, 16'h1234, "R2 write-all while disabled");

    sendCmd(OP_ENABLE, '0, '0); tick(); csIn = 1'b0;

    // R3: pending command waits for chip-select fall
    clearMon();
    sendCmd(OP_ERASE, 8'd7, '0);
    repeat (WORDC) tick();
    check(busyCnt == 0, "R3 no start while cs high", 64'(busyCnt), 0);
    dropCs(); waitIdle("R3"); checkCycle(OP_ERASE, 8'd7, '0, "R3 erase");

    runOp(OP_ERASE, 8'd0, '0, "R3 erase low address");
    runOp(OP_WRITE, 8'd255, 16'hA5C3, "R4 write top address");

    for (int n = 0; n < 12; n++) begin
      rop = ($urandom % 2) ? OP_WRITE : OP_ERASE;
      ra = AW'($urandom);
      rd = DW'($urandom);
      runOp(rop, ra, rd, rop == OP_WRITE ? "R4 random write" : "R3 random erase");
    end

    // R5 + R9 + R10: erase-all with status poll
    clearMon();
    sendCmd(OP_ERASE_ALL, '0, '0);
    dropCs();
    repeat (LOWMIN + 2) tick();
    csIn = 1'b1;
    tick();
    check(doOe && !doVal && busy, "R9 status shows busy", {doOe, doVal, busy}, 3'b101);
    waitIdle("R5");
    check(doOe && doVal, "R9 status shows ready", {doOe, doVal}, 2'b11);
    csIn = 1'b0;
    tick();
    check(!doOe, "R10 release on cs fall", 64'(doOe), 0);
    checkCycle(OP_ERASE_ALL, '0, '0, "R5 erase-all");

    // R6 + R9 short low + R10 held low
    clearMon();
    sendCmd(OP_WRITE_ALL, '0, 16'h3C5A);
    dropCs();
    repeat (LOWMIN - 2) tick();
    csIn = 1'b1;
    tick();
    check(!doOe, "R9 short low time no status", 64'(doOe), 0);
    csIn = 1'b0;
    waitIdle("R6");
    check(oeSeen == 0, "R10 stays released", 64'(oeSeen), 0);
    checkCycle(OP_WRITE_ALL, '0, 16'h3C5A, "R6 write-all");

    // R8: command during busy ignored, cs toggling harmless
    clearMon();
    sendCmd(OP_WRITE, 8'd40, 16'h0F0F);
    dropCs();
    repeat (3) tick();
    sendCmd(OP_WRITE, 8'd41, 16'hBEEF);
    dropCs();
    waitIdle("R8");
    repeat (WORDC + 5) tick();
    check(arr[41] === expArr[41], "R8 busy command ignored", 64'(arr[41]), 64'(expArr[41]));
    checkCycle(OP_WRITE, 8'd40, 16'h0F0F, "R8 cycle completes");

    // R7: disable then re-enable
    sendCmd(OP_DISABLE, '0, '0); tick(); csIn = 1'b0;
    noEffect(OP_WRITE, 8'd9, 16'h7777, "R7 write after disable");
    noEffect(OP_ERASE_ALL, 8'd9, '0, "R7 erase-all after disable");
    sendCmd(OP_ENABLE, '0, '0); tick(); csIn = 1'b0;
    runOp(OP_WRITE, 8'd9, 16'h7777, "R7 write after re-enable");

    // R11: power low
    pwrGood = 1'b0;
    noEffect(OP_ERASE, 8'd3, '0, "R11 erase with power low");
    pwrGood = 1'b1;
    clearMon();
    sendCmd(OP_WRITE, 8'd4, 16'h1357);
    dropCs();
    repeat (5) tick();
    pwrGood = 1'b0;
    tick();
    check(!busy, "R11 cycle aborted", 64'(busy), 0);
    repeat (WORDC) tick();
    check(weCount == 1, "R11 no writes after abort", 64'(weCount), 64'd1);
    expArr[4] = ONES;
    check(arr[4] === expArr[4], "R11 word after abort", 64'(arr[4]), 64'(expArr[4]));
    pwrGood = 1'b1;
    cmpAll("R11 array intact");

    done = 1;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule